// File: doc/BRIEF.md
# Serial Video Descrambler and Framer

This block is the receive-side decoder for a standard-definition serial digital video link. It runs on the recovered bit clock and takes in one line bit per cycle. First it turns the NRZI line coding back into NRZ. Next it reverses the self-synchronous scrambler. Last it packs the recovered bits into 10-bit words.

Word boundaries are not known when the stream starts. The block finds them on its own by searching the descrambled stream for the timing reference preamble (all-ones word, then two all-zero words) at every bit offset. A hit moves the word boundary to just after the last zero word.

Each word is presented with a one-cycle word-rate enable. When the word that follows a preamble (the line identification word) is presented, two active-low flags report it: one for any timing reference and one for an end-of-active-video reference. Downstream logic uses these flags to lock onto line timing.

Top module: `svd_rx`

## Requirements
- R1: A decoded NRZ bit equals the current line bit XOR the previous line bit. The line bit before the first bit after reset is taken as 0.
- R2: The descrambled bit n equals NRZ bit n XOR NRZ bit n-4 XOR NRZ bit n-9. History from before reset counts as 0.
- R3: Serial bits are assembled least significant bit first. The earliest bit of a word lands in bit 0 of `word_o`.
- R4: `word_vld_o` is high for one clock when a complete 10-bit word is placed on `word_o`. At all other times `word_o` holds its value.
- R5: The descrambled stream is compared against the 30-bit preamble (hex 3FF, then 000, then 000, in arrival order) at every bit position. A match realigns the word counter so that the next word begins with the bit that follows the final zero word.
- R6: While no new preamble arrives, `word_vld_o` pulses exactly once every 10 clocks. It is never high on two consecutive clocks.
- R7: `trs_n_o` is low for exactly one clock, in the same cycle that `word_vld_o` presents the first word after a preamble. It is high at all other times.
- R8: In that same cycle, `eav_n_o` is low if bit 6 of that word is 1 (end of active video). It stays high if bit 6 is 0 (start of active video). It is never low while `trs_n_o` is high.
- R9: A synchronous active-high reset clears the NRZI and descrambler history, the window and the alignment. In the cycle after a reset edge, `word_o` is 0, `word_vld_o` is 0 and both flags are 1. The first word after reset is presented 10 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | NRZI-coded scrambled line bit |
| word_o | output | 10 | Recovered parallel word |
| word_vld_o | output | 1 | Word-rate enable, one clock per word |
| trs_n_o | output | 1 | Timing reference seen, active low |
| eav_n_o | output | 1 | End-of-active-video reference seen, active low |

## Verification
Some output relations hold on every cycle, and the assertions check these. The flags appear only together with the word enable. A flag lasts one clock. The end-of-video flag agrees with bit 6 of the word shown. The enable never repeats on the next clock. The word holds steady between enables.

Other behaviour can only be shown by the bench's scenarios, which replay a stream through a behavioural queue model. These are: the actual NRZI and descrambling arithmetic, the least-significant-first ordering, finding a preamble three bits away from the free-running boundary, the exact 10-clock enable period, and the reset state in the middle of a run.

// File: rtl/svd_pkg.sv
package svd_pkg;
    // Default geometry of the serial video receive path.
    localparam int unsigned WORD_W_DEF     = 10; // bits per parallel word
    localparam int unsigned SCR_LEN_DEF    = 9;  // descrambler history length (x^9)
    localparam int unsigned SCR_TAP_DEF    = 4;  // inner feedback tap (x^4)
    localparam int unsigned SYNC_WORDS_DEF = 3;  // words in the preamble
    localparam int unsigned ID_H_BIT_DEF   = 6;  // end/start-of-video bit in the id word
endpackage

// File: rtl/svd_nrzi.sv
module svd_nrzi (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic nrz_o
);
    typedef struct packed {
        logic prev;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        nrz_o    = line_i ^ s_q.prev;
        s_d.prev = line_i;
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end
endmodule

// File: rtl/svd_descram.sv
module svd_descram #(
    parameter int unsigned LEN = svd_pkg::SCR_LEN_DEF,
    parameter int unsigned TAP = svd_pkg::SCR_TAP_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic nrz_i,
    output logic bit_o
);
    // hist[k] holds the NRZ bit from k+1 clocks ago
    typedef struct packed {
        logic [LEN-1:0] hist;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        bit_o    = nrz_i ^ s_q.hist[TAP-1] ^ s_q.hist[LEN-1];
        s_d.hist = {s_q.hist[LEN-2:0], nrz_i};
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end
endmodule

// File: rtl/svd_framer.sv
module svd_framer #(
    parameter int unsigned W     = svd_pkg::WORD_W_DEF,
    parameter int unsigned NSYNC = svd_pkg::SYNC_WORDS_DEF,
    parameter int unsigned HBIT  = svd_pkg::ID_H_BIT_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_i,
    output logic [W-1:0] word_o,
    output logic         vld_o,
    output logic         trs_n_o,
    output logic         eav_n_o
);
    localparam int unsigned WIN = W * NSYNC;
    localparam int unsigned CW  = $clog2(W + 1);
    // oldest word all ones, the later words all zeros (newest bit at the top)
    localparam logic [WIN-1:0] PREAMBLE = {{(WIN - W){1'b0}}, {W{1'b1}}};

    typedef struct packed {
        logic [WIN-1:0] win;
        logic [CW-1:0]  fill;
        logic           pend;
        logic [W-1:0]   word;
        logic           vld;
        logic           trs_n;
        logic           eav_n;
    } st_t;

    st_t  s_q, s_d;
    logic hit;
    logic full;

    always_comb begin
        s_d  = s_q;
        hit  = (s_q.win == PREAMBLE);
        full = (s_q.fill == CW'(W));

        s_d.win   = {bit_i, s_q.win[WIN-1:1]};
        s_d.vld   = full;
        s_d.trs_n = 1'b1;
        s_d.eav_n = 1'b1;

        if (full) begin
            s_d.word = s_q.win[WIN-1 -: W];
            if (s_q.pend) begin
                s_d.trs_n = 1'b0;
                s_d.eav_n = ~s_q.win[WIN - W + HBIT];
                s_d.pend  = 1'b0;
            end
        end

        if (hit) begin
            s_d.pend = 1'b1;
        end

        if (hit || full) begin
            s_d.fill = CW'(1);
        end else begin
            s_d.fill = s_q.fill + CW'(1);
        end

        if (rst) begin
            s_d       = '0;
            s_d.fill  = CW'(1);
            s_d.trs_n = 1'b1;
            s_d.eav_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign word_o  = s_q.word;
    assign vld_o   = s_q.vld;
    assign trs_n_o = s_q.trs_n;
    assign eav_n_o = s_q.eav_n;
endmodule

// File: rtl/svd_rx.sv
module svd_rx #(
    parameter int unsigned WORD_W     = svd_pkg::WORD_W_DEF,
    parameter int unsigned SCR_LEN    = svd_pkg::SCR_LEN_DEF,
    parameter int unsigned SCR_TAP    = svd_pkg::SCR_TAP_DEF,
    parameter int unsigned SYNC_WORDS = svd_pkg::SYNC_WORDS_DEF,
    parameter int unsigned ID_H_BIT   = svd_pkg::ID_H_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              trs_n_o,
    output logic              eav_n_o
);
    logic nrz;
    logic plain;

    svd_nrzi u_nrzi (
        .clk    (clk),
        .rst    (rst),
        .line_i (sdi),
        .nrz_o  (nrz)
    );

    svd_descram #(
        .LEN (SCR_LEN),
        .TAP (SCR_TAP)
    ) u_descram (
        .clk   (clk),
        .rst   (rst),
        .nrz_i (nrz),
        .bit_o (plain)
    );

    svd_framer #(
        .W     (WORD_W),
        .NSYNC (SYNC_WORDS),
        .HBIT  (ID_H_BIT)
    ) u_framer (
        .clk     (clk),
        .rst     (rst),
        .bit_i   (plain),
        .word_o  (word_o),
        .vld_o   (word_vld_o),
        .trs_n_o (trs_n_o),
        .eav_n_o (eav_n_o)
    );
endmodule

// File: rtl/svd_rx_chk.sv
module svd_rx_chk #(
    parameter int unsigned W  = svd_pkg::WORD_W_DEF,
    parameter int unsigned HB = svd_pkg::ID_H_BIT_DEF
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] word_o,
    input logic         word_vld_o,
    input logic         trs_n_o,
    input logic         eav_n_o
);
    AST_FLAG_WITH_WORD: assert property (@(posedge clk) disable iff (rst)
        !trs_n_o |-> word_vld_o); // R7

    AST_FLAG_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        !trs_n_o |=> trs_n_o); // R7

    AST_EAV_INSIDE_TRS: assert property (@(posedge clk) disable iff (rst)
        !eav_n_o |-> !trs_n_o); // R8

    AST_EAV_H_SET: assert property (@(posedge clk) disable iff (rst)
        !eav_n_o |-> word_o[HB]); // R8

    AST_SAV_H_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!trs_n_o && eav_n_o) |-> !word_o[HB]); // R8

    AST_VLD_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        word_vld_o |=> !word_vld_o); // R6

    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!word_vld_o && !$past(rst)) |-> $stable(word_o)); // R4
endmodule

bind svd_rx svd_rx_chk #(.W(WORD_W), .HB(ID_H_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .trs_n_o    (trs_n_o),
    .eav_n_o    (eav_n_o)
);

// File: tb/sim_svd_rx.sv
`timescale 1ns/1ps
module sim_svd_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sdi = 1'b0;
    logic [9:0] word_o;
    logic       word_vld_o;
    logic       trs_n_o;
    logic       eav_n_o;

    svd_rx u0 (
        .clk        (clk),
        .rst        (rst),
        .sdi        (sdi),
        .word_o     (word_o),
        .word_vld_o (word_vld_o),
        .trs_n_o    (trs_n_o),
        .eav_n_o    (eav_n_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    bit dq[$];
    bit nq[$];
    bit mprev;
    int mcnt;
    bit mpend;
    logic [9:0] e_word;
    logic e_vld, e_trs, e_eav;
    bit have_exp = 0;

    // transmit-side scrambler state
    bit sq[$];
    bit tprev;

    // observation
    int cyc = 0;
    int last_vld = -1;
    bit collecting = 0;
    int trs_cnt = 0;
    int eav_cnt = 0;
    logic [9:0] got[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit hist(ref bit q[$], input int back);
        if (back > q.size()) return 1'b0;
        return q[q.size() - back];
    endfunction

    task automatic model(input bit x, input bit r);
        bit hit, full, nrz, d;
        if (r) begin
            e_word = '0; e_vld = 1'b0; e_trs = 1'b1; e_eav = 1'b1;
            dq.delete(); nq.delete();
            mprev = 0; mcnt = 1; mpend = 0;
            return;
        end
        hit = 1;
        for (int k = 0; k < 30; k++) begin
            if (hist(dq, 30 - k) != (k < 10)) hit = 0;
        end
        full  = (mcnt == 10);
        e_vld = full;
        e_trs = 1'b1;
        e_eav = 1'b1;
        if (full) begin
            for (int i = 0; i < 10; i++) e_word[i] = hist(dq, 10 - i);
            if (mpend) begin
                e_trs = 1'b0;
                e_eav = ~e_word[6];
                mpend = 0;
            end
        end
        if (hit) mpend = 1;
        mcnt = (hit || full) ? 1 : mcnt + 1;
        nrz   = x ^ mprev;              // R1
        mprev = x;
        d = nrz ^ hist(nq, 4) ^ hist(nq, 9); // R2
        nq.push_back(nrz);
        dq.push_back(d);
    endtask

    task automatic observe();
        if (have_exp) begin
            chk(word_vld_o === e_vld, "R6", "word_vld", int'(word_vld_o), int'(e_vld));
            chk(word_o === e_word,    "R4", "word",     int'(word_o),     int'(e_word));
            chk(trs_n_o === e_trs,    "R7", "trs_n",    int'(trs_n_o),    int'(e_trs));
            chk(eav_n_o === e_eav,    "R8", "eav_n",    int'(eav_n_o),    int'(e_eav));
            if (rst === 1'b1) begin
                chk(word_o === 10'h000 && word_vld_o === 1'b0 &&
                    trs_n_o === 1'b1 && eav_n_o === 1'b1, "R9", "reset state",
                    int'({word_vld_o, trs_n_o, eav_n_o}), 3'b011);
            end
        end
        if (rst === 1'b1) begin
            collecting = 0;
            last_vld   = -1;
        end else begin
            if (word_vld_o === 1'b1) begin
                if (trs_n_o === 1'b0) collecting = 1;
                if (collecting) begin
                    got.push_back(word_o);
                    if (last_vld >= 0)
                        chk(cyc - last_vld == 10, "R6", "enable spacing", cyc - last_vld, 10);
                    last_vld = cyc;
                end
            end
            if (trs_n_o === 1'b0) trs_cnt++;
            if (eav_n_o === 1'b0) eav_cnt++;
        end
        cyc++;
    endtask

    task automatic step(input bit line, input bit r);
        @(negedge clk);
        observe();
        sdi = line;
        rst = r;
        model(line, r);
        have_exp = 1;
    endtask

    task automatic reset_cycles(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1);
        sq.delete();
        tprev = 0;
    endtask

    task automatic send_bit(input bit b);
        bit s;
        s = b ^ hist(sq, 4) ^ hist(sq, 9);
        sq.push_back(s);
        tprev = tprev ^ s;
        step(tprev, 1'b0);
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]); // R3 LSB first
    endtask

    task automatic send_trs(input logic [9:0] id);
        send_word(10'h3FF);
        send_word(10'h000);
        send_word(10'h000);
        send_word(id);
    endtask

    logic [9:0] exp_list[19] = '{10'h274, 10'h155, 10'h2AA, 10'h133, 10'h0CC,
                                 10'h3FF, 10'h000, 10'h000, 10'h200, 10'h1E1,
                                 10'h21E, 10'h3FF, 10'h000, 10'h000, 10'h2D8,
                                 10'h155, 10'h155, 10'h155, 10'h155};

    initial begin
        reset_cycles(3);
        // three stray bits put the stream off the free-running boundary
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        send_word(10'h155); send_word(10'h2AA); send_word(10'h0F0);
        send_trs(10'h274);                       // end of active video
        chk(trs_cnt == 0, "R5", "no flag before id word emitted", trs_cnt, 0);
        send_word(10'h155);
        chk(trs_cnt == 1, "R5", "misaligned preamble found", trs_cnt, 1);
        send_word(10'h2AA); send_word(10'h133); send_word(10'h0CC);
        send_trs(10'h200);                       // start of active video
        send_word(10'h1E1); send_word(10'h21E);
        chk(eav_cnt == 1, "R8", "start-of-video gives no eav", eav_cnt, 1);
        send_trs(10'h2D8);
        for (int i = 0; i < 6; i++) send_word(10'h155);
        chk(trs_cnt == 3, "R7", "trs pulse count", trs_cnt, 3);
        chk(eav_cnt == 2, "R8", "eav pulse count", eav_cnt, 2);
        chk(got.size() >= 19, "R4", "words collected", got.size(), 19);
        if (got.size() >= 19) begin
            chk(got[0] == 10'h274, "R1", "first id word", int'(got[0]), 10'h274);
            chk(got[1] == 10'h155, "R3", "bit order", int'(got[1]), 10'h155);
            for (int i = 0; i < 19; i++)
                chk(got[i] == exp_list[i], "R2", "decoded word", int'(got[i]), int'(exp_list[i]));
        end
        // reset in mid-run, then an aligned reference
        reset_cycles(2);
        send_trs(10'h274);
        send_word(10'h155); send_word(10'h155);
        chk(trs_cnt == 4, "R9", "trs after reset", trs_cnt, 4);
        chk(eav_cnt == 3, "R9", "eav after reset", eav_cnt, 3);
        @(negedge clk);
        observe();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule